// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in a receive path and decides, for each incoming Ethernet frame, whether the frame is kept or dropped, looking only at the destination address at the head of the frame. The address reaches it one byte per valid cycle, with a marker on the first byte. One cycle after the last address byte, the block raises a one-cycle decision strobe together with an accept flag. Later bytes of the frame pass by without effect.

The host programs six station address slots, a per-slot enable mask, a two-bit acceptance mode and an address-length option through a byte-wide write-only register port. The modes nest. The narrowest accepts only frames that hit an enabled station slot. The next also takes broadcast, the next also takes multicast, and the widest takes every frame. A frame that ends before its address is complete is rejected.

Register map: address bits [5:3] select a page and bits [2:0] select a byte within it. Pages 0 to 5 are the station slots, and byte 0 is the first address byte seen on the wire. Page 6, byte 0 holds the slot enables in bits 5:0. Page 6, byte 1 holds the mode in bits 1:0 and the short-address option in bit 2.

Top module: `dest_addr_filter`

## Requirements
- R1: A write with reg_addr = {slot, byte}, slot 0 to 5 and byte 0 to 5, stores reg_wdata as that byte of that station slot. Station byte k is compared with the k-th received address byte, counting from 0.
- R2: A write to page 6 byte 0 sets the slot enables, with bit s enabling slot s. A disabled slot never causes acceptance, even when its address matches exactly.
- R3: In mode 0, a frame is accepted only when its address equals the address of at least one enabled slot.
- R4: In mode 1, a frame is also accepted when its address is broadcast, meaning every compared byte is 0xFF.
- R5: In mode 2, a frame is accepted on a slot hit, on broadcast, or when bit 0 of its first address byte is 1 (multicast).
- R6: In mode 3, every frame whose address is complete is accepted.
- R7: After reset, only slot 0 is enabled, the mode is 1, the address is six bytes long and every station byte is 0x00.
- R8: When bit 2 of page 6 byte 1 is set, only the first two address bytes are compared and the decision follows the second byte. Broadcast then means both of those bytes are 0xFF.
- R9: dec_vld is high for exactly one cycle, in the cycle after the last address byte is taken. Further bytes without rx_first produce no strobe.
- R10: An rx_end pulse while an address is incomplete gives dec_vld in the next cycle with dec_accept low.
- R11: A byte marked rx_first restarts address collection, even in the middle of an earlier address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: page [5:3], byte [2:0] |
| reg_wdata | input | 8 | Register write data |
| rx_vld | input | 1 | Received byte valid |
| rx_first | input | 1 | Marks the first byte of a frame (qualified by rx_vld) |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Frame ended |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision result, meaningful while dec_vld is high |

## Verification
A full address gives its decision in the cycle after the last address byte is sampled: after the sixth byte, or after the second in short mode. An rx_end pulse on an incomplete address gives its reject strobe in the cycle after the pulse. The bench drives inputs on falling edges. It samples dec_vld and dec_accept on the falling edge that follows the edge that took the final byte or the end pulse, and checks on the next falling edge that the strobe has dropped. Register writes take effect on the edge that samples them, so a frame may start on the very next falling edge.

// File: rtl/adf_pkg.sv
package adf_pkg;

    localparam int NUM_SLOTS   = 6;
    localparam int ADDR_BYTES  = 6;
    localparam int SHORT_BYTES = 2;
    localparam int BYTE_W      = 8;
    localparam int PAGE_W      = 3;
    localparam int SUB_W       = 3;
    localparam int REG_AW      = PAGE_W + SUB_W;
    localparam int IDX_W       = $clog2(ADDR_BYTES);

    localparam logic [PAGE_W-1:0] CTRL_PAGE = PAGE_W'(NUM_SLOTS);
    localparam logic [SUB_W-1:0]  SUB_EN    = SUB_W'(0);
    localparam logic [SUB_W-1:0]  SUB_MODE  = SUB_W'(1);

    typedef enum logic [1:0] {
        MODE_SPECIFIC = 2'd0,
        MODE_BCAST    = 2'd1,
        MODE_MCAST    = 2'd2,
        MODE_ALL      = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic                 short_addr;
        match_mode_e          mode;
        logic [NUM_SLOTS-1:0] slot_en;
    } filt_cfg_t;

    typedef logic [ADDR_BYTES-1:0][BYTE_W-1:0] mac_addr_t;

    localparam filt_cfg_t CFG_RESET = '{
        short_addr: 1'b0,
        mode:       MODE_BCAST,
        slot_en:    NUM_SLOTS'(1)
    };

    // Nested acceptance: each wider mode keeps everything the narrower one takes.
    function automatic logic accept_fn(match_mode_e m, logic slot_hit,
                                       logic bcast, logic mcast);
        case (m)
            MODE_SPECIFIC: accept_fn = slot_hit;
            MODE_BCAST:    accept_fn = slot_hit | bcast;
            MODE_MCAST:    accept_fn = slot_hit | bcast | mcast;
            default:       accept_fn = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/adf_regs.sv
module adf_regs
    import adf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [REG_AW-1:0]                 wr_addr,
    input  logic [BYTE_W-1:0]                 wr_data,
    output filt_cfg_t                         cfg,
    output logic [NUM_SLOTS-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] stn
);
    logic [PAGE_W-1:0] page;
    logic [SUB_W-1:0]  sub;

    assign page = wr_addr[REG_AW-1:SUB_W];
    assign sub  = wr_addr[SUB_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            stn <= '0;
        end else if (wr_en) begin
            if (page == CTRL_PAGE) begin
                if (sub == SUB_EN)
                    cfg.slot_en <= wr_data[NUM_SLOTS-1:0];
                if (sub == SUB_MODE) begin
                    cfg.mode       <= match_mode_e'(wr_data[1:0]);
                    cfg.short_addr <= wr_data[2];
                end
            end
            for (int s = 0; s < NUM_SLOTS; s++)
                for (int b = 0; b < ADDR_BYTES; b++)
                    if (page == PAGE_W'(s) && sub == SUB_W'(b))
                        stn[s][b] <= wr_data;
        end
    end

    a_r7_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == CFG_RESET && stn == '0));

    a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && page == CTRL_PAGE && sub == SUB_EN)
        |=> cfg.slot_en == $past(wr_data[NUM_SLOTS-1:0]));

endmodule

// File: rtl/adf_seq.sv
module adf_seq
    import adf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_vld,
    input  logic             rx_first,
    input  logic             rx_end,
    input  logic             short_addr,
    output logic             take,
    output logic             first_take,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             early
);
    logic             busy;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] last_idx;

    assign last_idx   = short_addr ? IDX_W'(SHORT_BYTES - 1) : IDX_W'(ADDR_BYTES - 1);
    assign first_take = rx_vld & rx_first;
    assign take       = rx_vld & (rx_first | busy);
    assign idx        = first_take ? '0 : cnt;
    assign last       = take & (idx == last_idx);
    assign early      = rx_end & (busy | take) & ~last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (last || early) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            cnt  <= idx + IDX_W'(1);
        end
    end

    a_r10_end_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_end && busy) |=> !busy);

    a_r11_restart: assert property (@(posedge clk) disable iff (rst)
        (first_take && !last && !rx_end) |=> (busy && cnt == IDX_W'(1)));

    a_r9_idle_ignores: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rx_first) |-> !take);

endmodule

// File: rtl/adf_slot_cmp.sv
module adf_slot_cmp
    import adf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              first_take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    input  mac_addr_t         ref_addr,
    output logic              hit_now
);
    logic run;
    logic eq;

    assign eq      = (data == ref_addr[idx]);
    assign hit_now = eq & (first_take | run);

    always_ff @(posedge clk) begin
        if (rst)       run <= 1'b0;
        else if (take) run <= hit_now;
    end

    a_r1_miss_sticks: assert property (@(posedge clk) disable iff (rst)
        (take && !first_take && !run) |-> !hit_now);

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import adf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              rx_vld,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    output logic              dec_vld,
    output logic              dec_accept
);
    filt_cfg_t cfg;
    logic [NUM_SLOTS-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] stn;

    logic             take, first_take, last, early;
    logic [IDX_W-1:0] idx;
    logic [NUM_SLOTS:0] hit_now;   // top entry is the broadcast comparator
    logic             mc_q, mcast_now, any_hit, bcast_now;

    adf_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .cfg     (cfg),
        .stn     (stn)
    );

    adf_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .rx_vld     (rx_vld),
        .rx_first   (rx_first),
        .rx_end     (rx_end),
        .short_addr (cfg.short_addr),
        .take       (take),
        .first_take (first_take),
        .idx        (idx),
        .last       (last),
        .early      (early)
    );

    for (genvar g = 0; g <= NUM_SLOTS; g++) begin : g_cmp
        mac_addr_t ref_addr;
        if (g == NUM_SLOTS) begin : g_bc
            assign ref_addr = '1;
        end else begin : g_slot
            assign ref_addr = stn[g];
        end
        adf_slot_cmp u_cmp (
            .clk        (clk),
            .rst        (rst),
            .take       (take),
            .first_take (first_take),
            .idx        (idx),
            .data       (rx_data),
            .ref_addr   (ref_addr),
            .hit_now    (hit_now[g])
        );
    end

    assign any_hit   = |(hit_now[NUM_SLOTS-1:0] & cfg.slot_en);
    assign bcast_now = hit_now[NUM_SLOTS];
    assign mcast_now = first_take ? rx_data[0] : mc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q       <= 1'b0;
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            if (first_take) mc_q <= rx_data[0];
            dec_vld    <= last | early;
            dec_accept <= last & accept_fn(cfg.mode, any_hit, bcast_now, mcast_now);
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dec_vld |=> !dec_vld);

    a_r6_promisc: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && $past(last) && $past(cfg.mode) == MODE_ALL) |-> dec_accept);

    a_r10_early_reject: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !$past(last)) |-> !dec_accept);

    a_r2_none_enabled: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && $past(cfg.slot_en) == '0 && $past(cfg.mode) == MODE_SPECIFIC)
        |-> !dec_accept);

    a_r9_accept_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_vld);

endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       rx_vld = 1'b0, rx_first = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = '0;
    logic       dec_vld, dec_accept;

    always #10 clk = ~clk;

    dest_addr_filter u_dest_addr_filter (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_vld(rx_vld), .rx_first(rx_first),
        .rx_data(rx_data), .rx_end(rx_end), .dec_vld(dec_vld),
        .dec_accept(dec_accept)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] m_stn [6][6];
    logic [5:0] m_en    = 6'b000001;
    logic [1:0] m_mode  = 2'd1;
    bit         m_short = 1'b0;
    logic [7:0] fr [6];

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int addr_len();
        return m_short ? 2 : 6;
    endfunction

    function automatic bit ref_accept();
        bit hit = 0, bc = 1;
        for (int s = 0; s < 6; s++) begin
            bit eq = m_en[s];
            for (int b = 0; b < addr_len(); b++)
                if (fr[b] != m_stn[s][b]) eq = 0;
            if (eq) hit = 1;
        end
        for (int b = 0; b < addr_len(); b++)
            if (fr[b] != 8'hFF) bc = 0;
        case (m_mode)
            2'd0: return hit;
            2'd1: return hit | bc;
            2'd2: return hit | bc | fr[0][0];
            default: return 1;
        endcase
    endfunction

    task automatic reg_write(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (a[5:3] < 6 && a[2:0] < 6) m_stn[a[5:3]][a[2:0]] = d;
        else if (a == 6'o60) m_en = d[5:0];
        else if (a == 6'o61) begin m_mode = d[1:0]; m_short = d[2]; end
    endtask

    task automatic set_slot(int s, logic [7:0] b0, b1, b2, b3, b4, b5);
        logic [7:0] v [6];
        v = '{b0, b1, b2, b3, b4, b5};
        for (int b = 0; b < 6; b++) reg_write({3'(s), 3'(b)}, v[b]);
    endtask

    // Sends n address bytes (the first marked), optionally an end pulse, then
    // checks the strobe one falling edge later and its drop one edge after that.
    task automatic send(int n, bit end_early, bit exp, string req, bit trail);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_vld = 1; rx_first = (i == 0); rx_data = fr[i];
            if (i > 0) check(dec_vld == 0, req, dec_vld, 0);
        end
        @(negedge clk);
        rx_vld = 0; rx_first = 0;
        if (end_early) begin
            rx_end = 1;
            @(negedge clk);
            rx_end = 0;
        end
        check(dec_vld == 1, req, dec_vld, 1);
        check(dec_accept == exp, req, dec_accept, exp);
        @(negedge clk);
        check(dec_vld == 0, "R9", dec_vld, 0);
        if (trail) begin
            for (int i = 0; i < 3; i++) begin
                rx_vld = 1; rx_first = 0; rx_data = 8'hFF;
                @(negedge clk);
                check(dec_vld == 0, "R9", dec_vld, 0);
            end
            rx_vld = 0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int s = 0; s < 6; s++) for (int b = 0; b < 6; b++) m_stn[s][b] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        check(dec_vld == 0, "R7", dec_vld, 0);

        // R7: zero address hits default slot 0; broadcast accepted; multicast not
        fr = '{0, 0, 0, 0, 0, 0};                send(6, 0, 1, "R7", 1);
        fr = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}; send(6, 0, 1, "R7", 0);
        fr = '{8'h01, 0, 0, 0, 0, 0};            send(6, 0, 0, "R7", 0);
        reg_write(6'o61, 8'h02);
        send(6, 0, 1, "R5", 0);

        // R1/R3: slot 3 exact match in mode 0; one differing last byte rejects
        set_slot(3, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        reg_write(6'o60, 8'b001000);
        reg_write(6'o61, 8'h00);
        fr = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; send(6, 0, 1, "R1", 0);
        fr[5] = 8'h56;                           send(6, 0, 0, "R3", 0);
        fr = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}; send(6, 0, 0, "R3", 0);
        // R2: disabling the slot blocks an exact match
        reg_write(6'o60, 8'b000000);
        fr = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; send(6, 0, 0, "R2", 0);
        // R4: broadcast in mode 1
        reg_write(6'o61, 8'h01);
        fr = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}; send(6, 0, 1, "R4", 0);
        // R6: promiscuous
        reg_write(6'o61, 8'h03);
        fr = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC}; send(6, 0, 1, "R6", 0);
        // R10: early end rejects even in promiscuous mode
        send(4, 1, 0, "R10", 0);
        // R8: short mode compares two bytes
        reg_write(6'o60, 8'b001000);
        reg_write(6'o61, 8'h04);
        fr = '{8'h02, 8'h11, 8'h99, 8'h99, 8'h99, 8'h99}; send(2, 0, 1, "R8", 1);
        fr = '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}; send(2, 0, 0, "R8", 0);
        reg_write(6'o61, 8'h05);
        send(2, 0, 1, "R8", 0);
        // R11: restart mid-address
        reg_write(6'o61, 8'h00);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_vld = 1; rx_first = (i == 0); rx_data = 8'hEE;
        end
        fr = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; send(6, 0, 1, "R11", 0);

        // Random mix
        for (int f = 0; f < 300; f++) begin
            int n, pick;
            bit early_end;
            string tag;
            if (f % 25 == 0) begin
                for (int s = 0; s < 6; s++)
                    for (int b = 0; b < 6; b++) reg_write({3'(s), 3'(b)}, 8'($urandom));
                reg_write(6'o60, 8'($urandom));
                reg_write(6'o61, {5'd0, 1'(($urandom % 4) == 0), 2'($urandom)});
            end
            pick = $urandom % 4;
            for (int b = 0; b < 6; b++) begin
                case (pick)
                    0: fr[b] = m_stn[$urandom % 6][b];
                    1: fr[b] = 8'hFF;
                    default: fr[b] = 8'($urandom);
                endcase
            end
            if (pick == 0) begin
                int s = $urandom % 6;
                for (int b = 0; b < 6; b++) fr[b] = m_stn[s][b];
            end
            if (pick == 2) fr[0][0] = 1'b1;
            early_end = ($urandom % 10) == 0;
            n = early_end ? 1 + ($urandom % (addr_len() - 1)) : addr_len();
            if (early_end) tag = "R10";
            else if (m_short) tag = "R8";
            else case (m_mode)
                2'd0: tag = "R3";
                2'd1: tag = "R4";
                2'd2: tag = "R5";
                default: tag = "R6";
            endcase
            send(n, early_end, early_end ? 1'b0 : ref_accept(), tag, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule